// File: doc/BRIEF.md
# Channel-Status and User-Bit Double Buffer

This block collects the per-frame channel-status (C) and user (U) bits that a digital audio receiver recovers for two channels, A and B, and keeps them in two stages. The capture stage takes one frame at a time over a valid/ready stream and places each bit into a byte, least significant bit first. Frame f goes to byte f/8, bit f%8. When the receiver signals the start of a new block, the whole capture stage is copied into a host-visible stage in one clock cycle.

A host reads the host-visible stage through a single address window. Plain control pins choose what the window shows: C or U data, one channel only or both channels interleaved, and which channel. Other control pins suppress the C copy or the U copy, or shield the leading channel-status bytes from being overwritten. The selected channel's emphasis field and its first channel-status byte are always driven on dedicated outputs.

The frame stream drops `frm_ready` only in a cycle where `blk_start` is high. A frame offered in that cycle is held by the source until the next cycle. The read path has no back-pressure: every `rd_en` pulse is answered one cycle later with `rd_valid` and `rd_data`.

Top module: `cs_dbuf`

## Requirements
- R1: After reset every host-visible byte is 0x00, so every read returns 0x00 and `emph` and `cs_byte0` are 0.
- R2: An accepted frame with index f writes `frm_c[0]` (channel A) and `frm_c[1]` (channel B) into bit f%8 of byte f/8 of the capture stage, and does the same with `frm_u`. A `blk_start` cycle copies the capture stage to the host-visible stage. With `cfg_bsel`=0, `cfg_two_byte`=0 and `cfg_chs`=0, address k returns channel A C byte k.
- R3: With `cfg_bsel`=1 the window shows U bytes instead of C bytes, using the same address mapping.
- R4: With `cfg_two_byte`=1, even address 2k returns channel A byte k and odd address 2k+1 returns channel B byte k, whatever `cfg_chs` is.
- R5: With `cfg_two_byte`=0 and `cfg_chs`=1, address k returns channel B byte k.
- R6: While `cfg_c_inhibit`=1, a `blk_start` leaves the host-visible C bytes of both channels unchanged. U bytes still copy.
- R7: While `cfg_u_inhibit`=1 and `cfg_u_blkmode`=1, a `blk_start` leaves the host-visible U bytes unchanged. C bytes still copy.
- R8: While `cfg_u_blkmode`=0, `cfg_u_inhibit` has no effect and U bytes copy on `blk_start`.
- R9: While `cfg_protect`=1, a `blk_start` leaves C bytes 0 to PROT_BYTES-1 of both channels unchanged and copies the remaining C bytes.
- R10: `rd_valid` and `rd_data` appear in the cycle after `rd_en`. A read issued in the same cycle as `blk_start` returns the value from before the copy.
- R11: `emph` equals bits 5:3 of host-visible C byte 0 of the channel that `cfg_chs` selects, and `cs_byte0` equals that whole byte.
- R12: A read address at or above NB (one-byte mode) or 2*NB (two-byte mode) returns 0x00. A frame with index at or above FRAMES changes nothing.
- R13: `frm_ready` is low exactly in `blk_start` cycles. The host-visible stage changes only in the cycle after a `blk_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A frame's bits are offered |
| frm_ready | output | 1 | Frame accepted this cycle when high with frm_valid |
| frm_idx | input | FIW | Frame number within the block |
| frm_c | input | 2 | Channel-status bits, [0]=A, [1]=B |
| frm_u | input | 2 | User bits, [0]=A, [1]=B |
| blk_start | input | 1 | Block-boundary pulse; triggers the copy |
| cfg_bsel | input | 1 | Window shows C (0) or U (1) |
| cfg_protect | input | 1 | Shield leading C bytes from the copy |
| cfg_c_inhibit | input | 1 | Suppress the C copy |
| cfg_u_inhibit | input | 1 | Suppress the U copy (block mode only) |
| cfg_u_blkmode | input | 1 | U data is in block mode |
| cfg_two_byte | input | 1 | Interleaved A/B read packing |
| cfg_chs | input | 1 | Channel select, A (0) or B (1) |
| rd_en | input | 1 | Host read request |
| rd_addr | input | AW | Host window address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| emph | output | 3 | Emphasis field of the selected channel |
| cs_byte0 | output | 8 | First C byte of the selected channel |

## Verification
The bench builds the block with FRAMES=64, so each stage holds eight bytes per channel and PROT_BYTES=5 leaves three C bytes that are not shielded. This makes it practical to read every address of the window after each copy, in every combination of C/U selection, packing and channel, and to cover the out-of-range region of one-byte mode as well. Inhibit, protect and collision cases can then be told apart byte by byte. The byte pattern of each block is computed from a seed.

// File: rtl/cs_dbuf_pkg.sv
package cs_dbuf_pkg;
  typedef logic [7:0] octet_t;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  localparam int EMPH_LSB = 3;
  localparam int EMPH_W   = 3;

  function automatic logic [EMPH_W-1:0] emph_field(input octet_t b);
    return b[EMPH_LSB +: EMPH_W];
  endfunction
endpackage

// File: rtl/cs_dstage.sv
module cs_dstage
  import cs_dbuf_pkg::*;
#(
  parameter int FRAMES = 192,
  parameter int NB     = FRAMES / 8,
  parameter int FIW    = $clog2(FRAMES) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [FIW-1:0]           idx,
  input  logic [1:0]               bits,
  output octet_t [1:0][NB-1:0]     d
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  logic [BW-1:0] byte_sel;
  logic [2:0]    bit_sel;
  logic          in_range;

  always_comb begin
    byte_sel = idx[BW+2:3];
    bit_sel  = idx[2:0];
    in_range = (int'(idx) < FRAMES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d <= '0;
    end else if (wr && in_range) begin
      for (int ch = 0; ch < 2; ch++) begin
        d[ch][byte_sel][bit_sel] <= bits[ch];
      end
    end
  end
endmodule

// File: rtl/cs_estage.sv
module cs_estage
  import cs_dbuf_pkg::*;
#(
  parameter int NB       = 24,
  parameter int PROT     = 5,
  parameter bit HAS_PROT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer,
  input  logic                 protect,
  input  octet_t [1:0][NB-1:0] d,
  output octet_t [1:0][NB-1:0] e
);
  logic [NB-1:0] shield;

  for (genvar k = 0; k < NB; k++) begin : g_shield
    if (HAS_PROT && (k < PROT)) begin : g_on
      assign shield[k] = protect;
    end else begin : g_off
      assign shield[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e <= '0;
    end else if (xfer) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int k = 0; k < NB; k++) begin
          if (!shield[k]) e[ch][k] <= d[ch][k];
        end
      end
    end
  end
endmodule

// File: rtl/cs_window.sv
module cs_window
  import cs_dbuf_pkg::*;
#(
  parameter int NB = 24,
  parameter int AW = $clog2(2 * NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  octet_t [1:0][NB-1:0] e_c,
  input  octet_t [1:0][NB-1:0] e_u,
  input  logic                 bsel,
  input  logic                 two_byte,
  input  logic                 chs,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rd_valid,
  output octet_t               rd_data
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  octet_t [1:0][NB-1:0] src;
  octet_t               val;
  logic [BW-1:0]        k1;
  logic [BW-1:0]        k2;
  chan_e                ch2;

  always_comb begin
    src = bsel ? e_u : e_c;
    k1  = rd_addr[BW-1:0];
    k2  = rd_addr[AW-1:1];
    ch2 = chan_e'(rd_addr[0]);
    val = '0;
    if (two_byte) begin
      if (int'(rd_addr) < 2 * NB) val = src[ch2][k2];
    end else begin
      if (int'(rd_addr) < NB) val = src[chs][k1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= val;
    end
  end
endmodule

// File: rtl/cs_dbuf.sv
module cs_dbuf
  import cs_dbuf_pkg::*;
#(
  parameter int FRAMES     = 192,
  parameter int PROT_BYTES = 5,
  parameter int NB         = FRAMES / 8,
  parameter int FIW        = $clog2(FRAMES) + 1,
  parameter int AW         = $clog2(2 * NB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frm_valid,
  output logic           frm_ready,
  input  logic [FIW-1:0] frm_idx,
  input  logic [1:0]     frm_c,
  input  logic [1:0]     frm_u,
  input  logic           blk_start,
  input  logic           cfg_bsel,
  input  logic           cfg_protect,
  input  logic           cfg_c_inhibit,
  input  logic           cfg_u_inhibit,
  input  logic           cfg_u_blkmode,
  input  logic           cfg_two_byte,
  input  logic           cfg_chs,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_valid,
  output logic [7:0]     rd_data,
  output logic [2:0]     emph,
  output logic [7:0]     cs_byte0
);
  octet_t [1:0][NB-1:0] d_c, d_u, e_c, e_u;
  logic                 accept;
  logic                 xfer_c;
  logic                 xfer_u;
  octet_t               sel_b0;

  assign frm_ready = ~blk_start;
  assign accept    = frm_valid & frm_ready;
  assign xfer_c    = blk_start & ~cfg_c_inhibit;
  assign xfer_u    = blk_start & ~(cfg_u_inhibit & cfg_u_blkmode);

  cs_dstage #(.FRAMES(FRAMES), .NB(NB), .FIW(FIW)) u_dc (
    .clk(clk), .rst_n(rst_n), .wr(accept), .idx(frm_idx), .bits(frm_c), .d(d_c));

  cs_dstage #(.FRAMES(FRAMES), .NB(NB), .FIW(FIW)) u_du (
    .clk(clk), .rst_n(rst_n), .wr(accept), .idx(frm_idx), .bits(frm_u), .d(d_u));

  cs_estage #(.NB(NB), .PROT(PROT_BYTES), .HAS_PROT(1'b1)) u_ec (
    .clk(clk), .rst_n(rst_n), .xfer(xfer_c), .protect(cfg_protect), .d(d_c), .e(e_c));

  cs_estage #(.NB(NB), .PROT(PROT_BYTES), .HAS_PROT(1'b0)) u_eu (
    .clk(clk), .rst_n(rst_n), .xfer(xfer_u), .protect(1'b0), .d(d_u), .e(e_u));

  cs_window #(.NB(NB), .AW(AW)) u_win (
    .clk(clk), .rst_n(rst_n), .e_c(e_c), .e_u(e_u), .bsel(cfg_bsel),
    .two_byte(cfg_two_byte), .chs(cfg_chs), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data));

  assign sel_b0   = e_c[cfg_chs][0];
  assign emph     = emph_field(sel_b0);
  assign cs_byte0 = sel_b0;
endmodule

// File: rtl/cs_dbuf_chk.sv
module cs_dbuf_chk
  import cs_dbuf_pkg::*;
#(
  parameter int NB   = 24,
  parameter int PROT = 5,
  parameter int AW   = $clog2(2 * NB)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 blk_start,
  input logic                 cfg_c_inhibit,
  input logic                 cfg_u_inhibit,
  input logic                 cfg_u_blkmode,
  input logic                 cfg_protect,
  input logic                 cfg_two_byte,
  input logic                 rd_en,
  input logic [AW-1:0]        rd_addr,
  input logic                 rd_valid,
  input logic [7:0]           rd_data,
  input octet_t [1:0][NB-1:0] d_c,
  input octet_t [1:0][NB-1:0] e_c,
  input octet_t [1:0][NB-1:0] e_u
);
  logic addr_ok;
  assign addr_ok = cfg_two_byte ? (int'(rd_addr) < 2 * NB) : (int'(rd_addr) < NB);

  // R2: unshielded, uninhibited copy makes E equal to the prior D
  a_r2_copy: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && !cfg_c_inhibit && !cfg_protect |=> e_c == $past(d_c));

  a_r6_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && cfg_c_inhibit |=> $stable(e_c));

  a_r7_u_hold: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && cfg_u_inhibit && cfg_u_blkmode |=> $stable(e_u));

  a_r9_shield: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start && cfg_protect |=> $stable(e_c[0][PROT-1:0]) && $stable(e_c[1][PROT-1:0]));

  a_r10_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r10_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r12_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !addr_ok |=> rd_data == 8'h00);

  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(e_c) && $stable(e_u));
endmodule

bind cs_dbuf cs_dbuf_chk #(.NB(NB), .PROT(PROT_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .cfg_c_inhibit(cfg_c_inhibit),
  .cfg_u_inhibit(cfg_u_inhibit), .cfg_u_blkmode(cfg_u_blkmode), .cfg_protect(cfg_protect),
  .cfg_two_byte(cfg_two_byte), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .d_c(d_c), .e_c(e_c), .e_u(e_u));

// File: tb/sim_cs_dbuf.sv
`timescale 1ns/1ps
module sim_cs_dbuf;
  localparam int FRAMES = 64;
  localparam int PROT   = 5;
  localparam int NB     = FRAMES / 8;
  localparam int FIW    = $clog2(FRAMES) + 1;
  localparam int AW     = $clog2(2 * NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, frm_ready;
  logic [FIW-1:0] frm_idx = '0;
  logic [1:0] frm_c = '0, frm_u = '0;
  logic blk_start = 1'b0;
  logic cfg_bsel = 0, cfg_protect = 0, cfg_c_inhibit = 0, cfg_u_inhibit = 0;
  logic cfg_u_blkmode = 0, cfg_two_byte = 0, cfg_chs = 0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [7:0] rd_data, cs_byte0;
  logic [2:0] emph;

  int n_chk = 0, n_bad = 0;
  logic [7:0] dc[2][NB], du[2][NB], ec[2][NB], eu[2][NB];

  always #2 clk = ~clk;

  cs_dbuf #(.FRAMES(FRAMES), .PROT_BYTES(PROT)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_idx(frm_idx), .frm_c(frm_c), .frm_u(frm_u), .blk_start(blk_start),
    .cfg_bsel(cfg_bsel), .cfg_protect(cfg_protect), .cfg_c_inhibit(cfg_c_inhibit),
    .cfg_u_inhibit(cfg_u_inhibit), .cfg_u_blkmode(cfg_u_blkmode),
    .cfg_two_byte(cfg_two_byte), .cfg_chs(cfg_chs), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .emph(emph), .cs_byte0(cs_byte0));

  function automatic logic [7:0] pat(int kind, int ch, int k, int seed);
    return 8'((k * 37 + ch * 91 + kind * 53 + seed * 29 + 7) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: frame f carries bit f%8 of byte f/8, channels A and B
  task automatic send_block(int seed);
    for (int f = 0; f < FRAMES; f++) begin
      @(negedge clk);
      frm_valid = 1'b1;
      frm_idx   = FIW'(f);
      for (int ch = 0; ch < 2; ch++) begin
        frm_c[ch] = pat(0, ch, f / 8, seed)[f % 8];
        frm_u[ch] = pat(1, ch, f / 8, seed)[f % 8];
      end
    end
    @(negedge clk);
    frm_valid = 1'b0;
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < NB; k++) begin
        dc[ch][k] = pat(0, ch, k, seed);
        du[ch][k] = pat(1, ch, k, seed);
      end
  endtask

  function automatic void model_copy();
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < NB; k++) begin
        if (!cfg_c_inhibit && !(cfg_protect && k < PROT)) ec[ch][k] = dc[ch][k];
        if (!(cfg_u_inhibit && cfg_u_blkmode)) eu[ch][k] = du[ch][k];
      end
  endfunction

  task automatic trigger();
    @(negedge clk);
    blk_start = 1'b1;
    #1 chk("R13 frm_ready low during blk_start", 32'(frm_ready), 0);
    @(negedge clk);
    blk_start = 1'b0;
    model_copy();
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic check_all(string ctx);
    logic [7:0] v, x;
    string t;
    for (int b = 0; b < 2; b++)
      for (int tw = 0; tw < 2; tw++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          cfg_bsel = b[0]; cfg_two_byte = tw[0]; cfg_chs = c[0];
          #1;
          chk({ctx, " R11 emph"}, 32'(emph), 32'(ec[c][0][5:3]));
          chk({ctx, " R11 cs_byte0"}, 32'(cs_byte0), 32'(ec[c][0]));
          for (int a = 0; a < (1 << AW); a++) begin
            if (tw == 1) x = (a < 2 * NB) ? (b ? eu[a % 2][a / 2] : ec[a % 2][a / 2]) : 8'h00;
            else         x = (a < NB) ? (b ? eu[c][a] : ec[c][a]) : 8'h00;
            if ((tw == 1 && a >= 2 * NB) || (tw == 0 && a >= NB)) t = "R12";
            else if (tw == 1) t = "R4";
            else if (b == 1) t = "R3";
            else if (c == 1) t = "R5";
            else t = "R2";
            rd(a, v);
            chk($sformatf("%s %s bsel=%0d two=%0d chs=%0d addr=%0d", ctx, t, b, tw, c, a), 32'(v), 32'(x));
          end
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < NB; k++) begin
        dc[ch][k] = 0; du[ch][k] = 0; ec[ch][k] = 0; eu[ch][k] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rd_valid after reset", 32'(rd_valid), 0);
    check_all("R1");

    send_block(1); trigger(); check_all("R2");

    cfg_c_inhibit = 1'b1;
    send_block(2); trigger(); check_all("R6");
    cfg_c_inhibit = 1'b0;

    cfg_u_inhibit = 1'b1; cfg_u_blkmode = 1'b1;
    send_block(3); trigger(); check_all("R7");

    cfg_u_blkmode = 1'b0;
    send_block(4); trigger(); check_all("R8");
    cfg_u_inhibit = 1'b0;

    cfg_protect = 1'b1;
    send_block(5); trigger(); check_all("R9");
    cfg_protect = 1'b0;

    // R10: read colliding with the copy returns the old byte
    send_block(6);
    @(negedge clk);
    cfg_bsel = 0; cfg_two_byte = 0; cfg_chs = 0;
    rd_en = 1'b1; rd_addr = AW'(2); blk_start = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; blk_start = 1'b0;
    chk("R10 rd_valid one cycle later", 32'(rd_valid), 1);
    chk("R10 collision read returns pre-copy byte", 32'(rd_data), 32'(ec[0][2]));
    model_copy();
    check_all("R10");

    // R12: out-of-range frame index changes nothing
    @(negedge clk);
    frm_valid = 1'b1; frm_idx = FIW'(FRAMES); frm_c = 2'b11; frm_u = 2'b11;
    @(negedge clk);
    frm_valid = 1'b0;
    frm_idx = FIW'(FRAMES + 9);
    trigger(); check_all("R12");

    // R13: new frames without blk_start leave E untouched
    send_block(7);
    repeat (4) @(negedge clk);
    check_all("R13");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule